// File: doc/BRIEF.md
# Audio Output Volume Control Register Bank

This block holds the small set of 16-bit control registers that set the output volume of a stereo audio codec. A host reaches it through a simple synchronous register bus: a valid strobe, a write enable, a 7-bit register index and 16-bit write data. Read data comes back on a registered 16-bit port. The bank holds one identification word and two stereo volume registers. For each of the line path and the headphone path, it drives a mute bit and a 5-bit attenuation code per channel.

A headphone-configuration input sets what the volume registers mean. With the input high, index 02h sets the line path and index 04h sets the headphone path. With the input low, index 02h sets the headphone path, the line path has no controlling register, and index 04h becomes a read-only zero. A write of any value to index 00h returns the whole bank to its defaults. Each attenuation field accepts a 6-bit code and saturates it to the largest 5-bit code when its top bit is set.

Top module: `mix_ctl_bank`

## Requirements
- R1: After the asynchronous reset rst_ni, both volume registers read 8000h with the configuration input high. Every path output then shows mute 1 with attenuation codes 0.
- R2: A read of index 00h returns 0190h when hp_cfg_i is 1 and 0180h when hp_cfg_i is 0. Bits 8 and 7 are always 1, and bit 4 equals hp_cfg_i.
- R3: In a volume register, bit 15 is mute, bits 13:8 are the left attenuation field and bits 5:0 are the right attenuation field. Bits 14, 7 and 6 read 0 whatever was written. Code 0 means 0 dB, and each code step adds 1.5 dB of attenuation.
- R4: A written attenuation field with bit 5 set is stored as 011111. It reads back as 011111 and drives the code 31 (-46.5 dB) on the output.
- R5: A write of any data to index 00h restores both volume registers to 8000h. The outputs show the defaults in the cycle after that write.
- R6: With hp_cfg_i at 1, register 02h drives the line_* outputs and register 04h drives the hp_* outputs.
- R7: With hp_cfg_i at 0, register 02h drives the hp_* outputs. The line_* outputs are held at mute 1 with codes 0.
- R8: With hp_cfg_i at 0, index 04h reads 0000h and writes to it are ignored. Its stored value reappears once hp_cfg_i returns to 1.
- R9: Indices other than 00h, 02h and 04h read 0000h. Writes to them change no register and no output.
- R10: rd_data_o takes the read result in the cycle after a read request and holds it until the next read. A volume write reaches the outputs in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hp_cfg_i | input | 1 | Headphone configuration (1 = floating/high, 0 = tied low) |
| req_valid_i | input | 1 | Bus request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 7 | Register index |
| req_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| line_mute_o | output | 1 | Line path mute |
| line_att_l_o | output | 5 | Line path left attenuation code |
| line_att_r_o | output | 5 | Line path right attenuation code |
| hp_mute_o | output | 1 | Headphone path mute |
| hp_att_l_o | output | 5 | Headphone path left attenuation code |
| hp_att_r_o | output | 5 | Headphone path right attenuation code |

## Verification
Read data is due one clock after the read request and then holds. Register writes and the soft reset change the path outputs one clock after the write. A change of the configuration input remaps the outputs and the identification bit in the same cycle, with no clock edge needed. The bench drives every request on a falling edge and samples at the next falling edge, so each read or write result falls exactly one rising edge after its stimulus. Configuration changes are sampled a full cycle after they are applied.

// File: rtl/mix_ctl_pkg.sv
package mix_ctl_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned ATT_W  = 5;
  localparam int unsigned FLD_W  = ATT_W + 1;
  localparam int unsigned MUTE_BIT = 15;
  localparam int unsigned L_LSB    = 8;
  localparam int unsigned R_LSB    = 0;
  localparam int unsigned NUM_VOL  = 2;

  localparam logic [IDX_W-1:0] IDX_ID     = 7'h00;
  localparam logic [IDX_W-1:0] IDX_VOL_A  = 7'h02;
  localparam logic [IDX_W-1:0] IDX_VOL_B  = 7'h04;

  localparam logic [DATA_W-1:0] CAP_BASE = 16'h0180;
  localparam int unsigned       CAP_HP_BIT = 4;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] att_l;
    logic [ATT_W-1:0] att_r;
  } vol_t;

  localparam vol_t VOL_DEFAULT = '{mute: 1'b1, att_l: '0, att_r: '0};

  function automatic logic [ATT_W-1:0] sat_code(input logic [FLD_W-1:0] fld);
    return fld[FLD_W-1] ? {ATT_W{1'b1}} : fld[ATT_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] vol_pack(input vol_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MUTE_BIT]          = v.mute;
    w[L_LSB +: ATT_W]    = v.att_l;
    w[R_LSB +: ATT_W]    = v.att_r;
    return w;
  endfunction
endpackage

// File: rtl/mix_vol_reg.sv
module mix_vol_reg
  import mix_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_en_i,
  input  logic             mute_i,
  input  logic [FLD_W-1:0] fld_l_i,
  input  logic [FLD_W-1:0] fld_r_i,
  output vol_t             q_o
);
  vol_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= VOL_DEFAULT;
    end else if (soft_rst_i) begin
      q <= VOL_DEFAULT;
    end else if (wr_en_i) begin
      q.mute  <= mute_i;
      q.att_l <= sat_code(fld_l_i);
      q.att_r <= sat_code(fld_r_i);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/mix_rd_mux.sv
module mix_rd_mux
  import mix_ctl_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hp_cfg_i,
  input  vol_t              vol_a_i,
  input  vol_t              vol_b_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_ID: begin
        rdata_o = CAP_BASE;
        rdata_o[CAP_HP_BIT] = hp_cfg_i;
      end
      IDX_VOL_A: rdata_o = vol_pack(vol_a_i);
      IDX_VOL_B: rdata_o = hp_cfg_i ? vol_pack(vol_b_i) : '0;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mix_path_map.sv
module mix_path_map
  import mix_ctl_pkg::*;
(
  input  logic hp_cfg_i,
  input  vol_t vol_a_i,
  input  vol_t vol_b_i,
  output vol_t line_o,
  output vol_t hp_o
);
  always_comb begin
    if (hp_cfg_i) begin
      line_o = vol_a_i;
      hp_o   = vol_b_i;
    end else begin
      // line path has no controlling register in this configuration
      line_o = VOL_DEFAULT;
      hp_o   = vol_a_i;
    end
  end
endmodule

// File: rtl/mix_ctl_bank.sv
module mix_ctl_bank
  import mix_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hp_cfg_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              line_mute_o,
  output logic [ATT_W-1:0]  line_att_l_o,
  output logic [ATT_W-1:0]  line_att_r_o,
  output logic              hp_mute_o,
  output logic [ATT_W-1:0]  hp_att_l_o,
  output logic [ATT_W-1:0]  hp_att_r_o
);
  localparam logic [IDX_W-1:0] VOL_IDX [NUM_VOL] = '{IDX_VOL_A, IDX_VOL_B};

  logic              wr_req;
  logic              soft_rst;
  logic [NUM_VOL-1:0] vol_wr;
  vol_t              vol_q [NUM_VOL];
  vol_t              line_v, hp_v;
  logic [DATA_W-1:0] rd_comb;
  logic [DATA_W-1:0] rd_q;
  logic              unused_wbits;

  assign wr_req   = req_valid_i && req_we_i;
  assign soft_rst = wr_req && (req_idx_i == IDX_ID);
  assign unused_wbits = ^{req_wdata_i[14], req_wdata_i[7:6]};

  for (genvar i = 0; i < NUM_VOL; i++) begin : g_vol
    // register B is read-only zero when headphone config is low
    if (i == 1) begin : g_gated
      assign vol_wr[i] = wr_req && (req_idx_i == VOL_IDX[i]) && hp_cfg_i;
    end else begin : g_plain
      assign vol_wr[i] = wr_req && (req_idx_i == VOL_IDX[i]);
    end

    mix_vol_reg u_vol (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_en_i    (vol_wr[i]),
      .mute_i     (req_wdata_i[MUTE_BIT]),
      .fld_l_i    (req_wdata_i[L_LSB +: FLD_W]),
      .fld_r_i    (req_wdata_i[R_LSB +: FLD_W]),
      .q_o        (vol_q[i])
    );
  end

  mix_rd_mux u_rd (
    .idx_i    (req_idx_i),
    .hp_cfg_i (hp_cfg_i),
    .vol_a_i  (vol_q[0]),
    .vol_b_i  (vol_q[1]),
    .rdata_o  (rd_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rd_q <= '0;
    else if (req_valid_i && !req_we_i)  rd_q <= rd_comb;
  end

  mix_path_map u_map (
    .hp_cfg_i (hp_cfg_i),
    .vol_a_i  (vol_q[0]),
    .vol_b_i  (vol_q[1]),
    .line_o   (line_v),
    .hp_o     (hp_v)
  );

  assign rd_data_o    = rd_q;
  assign line_mute_o  = line_v.mute;
  assign line_att_l_o = line_v.att_l;
  assign line_att_r_o = line_v.att_r;
  assign hp_mute_o    = hp_v.mute;
  assign hp_att_l_o   = hp_v.att_l;
  assign hp_att_r_o   = hp_v.att_r;
endmodule

// File: rtl/mix_ctl_bank_chk.sv
module mix_ctl_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hp_cfg_i,
  input logic        req_valid_i,
  input logic        req_we_i,
  input logic [6:0]  req_idx_i,
  input logic [15:0] rd_data_o,
  input logic        line_mute_o,
  input logic [4:0]  line_att_l_o,
  input logic [4:0]  line_att_r_o,
  input logic        hp_mute_o,
  input logic [4:0]  hp_att_l_o,
  input logic [4:0]  hp_att_r_o
);
  logic rd_req, wr_req;
  assign rd_req = req_valid_i && !req_we_i;
  assign wr_req = req_valid_i && req_we_i;

  // R2
  id_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_req && req_idx_i == 7'h00) |->
      (rd_data_o[15:9] == 7'd0) && (rd_data_o[8:7] == 2'b11) &&
      (rd_data_o[4] == $past(hp_cfg_i)));

  // R3
  vol_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_req && (req_idx_i == 7'h02 || req_idx_i == 7'h04)) |->
      (rd_data_o[14:13] == 2'b00) && (rd_data_o[7:5] == 3'b000));

  // R5
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_req && req_idx_i == 7'h00) |->
      hp_mute_o && (hp_att_l_o == 5'd0) && (hp_att_r_o == 5'd0) &&
      line_mute_o && (line_att_l_o == 5'd0) && (line_att_r_o == 5'd0));

  // R7
  line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hp_cfg_i |-> line_mute_o && (line_att_l_o == 5'd0) && (line_att_r_o == 5'd0));

  // R8
  ro_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_req && req_idx_i == 7'h04 && !hp_cfg_i) |-> rd_data_o == 16'h0000);

  // R9
  unimpl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_req && req_idx_i != 7'h00 && req_idx_i != 7'h02 && req_idx_i != 7'h04)
      |-> rd_data_o == 16'h0000);

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_req) |-> $stable(rd_data_o));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_req) && $stable(hp_cfg_i)) |->
      $stable({hp_mute_o, hp_att_l_o, hp_att_r_o, line_mute_o, line_att_l_o, line_att_r_o}));
endmodule

bind mix_ctl_bank mix_ctl_bank_chk u_chk (.*);

// File: tb/mix_ctl_bank_test.sv
module mix_ctl_bank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hp_cfg = 1'b1;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        line_mute, hp_mute;
  logic [4:0]  line_l, line_r, hp_l, hp_r;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mix_ctl_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .hp_cfg_i(hp_cfg),
    .req_valid_i(valid), .req_we_i(we), .req_idx_i(idx), .req_wdata_i(wdata),
    .rd_data_o(rdata),
    .line_mute_o(line_mute), .line_att_l_o(line_l), .line_att_r_o(line_r),
    .hp_mute_o(hp_mute), .hp_att_l_o(hp_l), .hp_att_r_o(hp_r)
  );

  function automatic logic [15:0] ow(input logic m, input logic [4:0] l, input logic [4:0] r);
    return {5'd0, m, l, r};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input logic m, input logic [4:0] l, input logic [4:0] r);
    chk(req, "line outputs", ow(line_mute, line_l, line_r), ow(m, l, r));
  endtask

  task automatic chk_hp(input string req, input logic m, input logic [4:0] l, input logic [4:0] r);
    chk(req, "hp outputs", ow(hp_mute, hp_l, hp_r), ow(m, l, r));
  endtask

  // drive at negedge, result due at the following negedge
  task automatic bus_wr(input logic [6:0] i, input logic [15:0] d);
    valid = 1'b1; we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] i, output logic [15:0] d);
    valid = 1'b1; we = 1'b0; idx = i;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic set_cfg(input logic c);
    hp_cfg = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1", "line after reset", ow(line_mute, line_l, line_r), ow(1'b1, 5'd0, 5'd0));
    chk_hp("R1", 1'b1, 5'd0, 5'd0);
    bus_rd(7'h02, d); chk("R1", "reg 02h default", d, 16'h8000);
    bus_rd(7'h04, d); chk("R1", "reg 04h default", d, 16'h8000);
  endtask

  task automatic t_id;
    logic [15:0] d;
    bus_rd(7'h00, d); chk("R2", "id cfg high", d, 16'h0190);
    set_cfg(1'b0);
    bus_rd(7'h00, d); chk("R2", "id cfg low", d, 16'h0180);
    set_cfg(1'b1);
  endtask

  task automatic t_layout;
    logic [15:0] d;
    bus_wr(7'h02, 16'h8A05);
    chk_line("R10", 1'b1, 5'd10, 5'd5);
    bus_rd(7'h02, d); chk("R3", "plain readback", d, 16'h8A05);
    @(negedge clk);
    chk("R10", "read data held", rdata, 16'h8A05);
    bus_wr(7'h02, 16'h5F40);
    bus_rd(7'h02, d); chk("R3", "unused bits read 0", d, 16'h1F00);
    chk_line("R3", 1'b0, 5'd31, 5'd0);
  endtask

  task automatic t_map_high;
    bus_wr(7'h02, 16'h0C07);
    bus_wr(7'h04, 16'h0203);
    chk_line("R6", 1'b0, 5'd12, 5'd7);
    chk_hp("R6", 1'b0, 5'd2, 5'd3);
  endtask

  task automatic t_sat;
    logic [15:0] d;
    bus_wr(7'h02, 16'h2021);
    bus_rd(7'h02, d); chk("R4", "saturated readback", d, 16'h1F1F);
    chk_line("R4", 1'b0, 5'd31, 5'd31);
    bus_wr(7'h02, 16'h3F1E);
    bus_rd(7'h02, d); chk("R4", "left sat right plain", d, 16'h1F1E);
  endtask

  task automatic t_cfg_low;
    logic [15:0] d;
    set_cfg(1'b0);
    chk_hp("R7", 1'b0, 5'd31, 5'd30);
    chk_line("R7", 1'b1, 5'd0, 5'd0);
    bus_wr(7'h04, 16'h1111);
    bus_rd(7'h04, d); chk("R8", "04h reads zero", d, 16'h0000);
    chk_hp("R8", 1'b0, 5'd31, 5'd30);
    set_cfg(1'b1);
    bus_rd(7'h04, d); chk("R8", "04h kept value", d, 16'h0203);
    chk_hp("R6", 1'b0, 5'd2, 5'd3);
  endtask

  task automatic t_unimpl;
    logic [15:0] d;
    bus_wr(7'h06, 16'h1234);
    bus_wr(7'h7E, 16'hFFFF);
    bus_rd(7'h06, d); chk("R9", "06h reads zero", d, 16'h0000);
    bus_rd(7'h7E, d); chk("R9", "7Eh reads zero", d, 16'h0000);
    bus_rd(7'h02, d); chk("R9", "02h unchanged", d, 16'h1F1E);
    chk_hp("R9", 1'b0, 5'd2, 5'd3);
  endtask

  task automatic t_soft_rst;
    logic [15:0] d;
    bus_wr(7'h00, 16'h0000);
    chk_line("R5", 1'b1, 5'd0, 5'd0);
    chk_hp("R5", 1'b1, 5'd0, 5'd0);
    bus_rd(7'h02, d); chk("R5", "02h after soft reset", d, 16'h8000);
    bus_wr(7'h04, 16'h0505);
    set_cfg(1'b0);
    bus_wr(7'h00, 16'hABCD);
    set_cfg(1'b1);
    bus_rd(7'h04, d); chk("R5", "04h reset while cfg low", d, 16'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_layout();
    t_map_high();
    t_sat();
    t_cfg_low();
    t_unimpl();
    t_soft_rst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule